// File: doc/BRIEF.md
# Guarded byte-store access controller

This block sits on a small CPU register bus and gives software byte-wide read and write access to a 512-entry nonvolatile store. Software loads a 9-bit byte address through two address registers and stages a byte in a data register. It then starts an access from a control register. The store itself is behavioural and lives outside the block. The controller drives the store's address, write data and strobes, and it takes the fetched byte back.

Writes are guarded. An arming bit must be set first, and the write request counts only if it lands while the arming window is open. The window lasts four cycles and then hardware closes it. A write holds the controller busy for a fixed latency. During that time the request bit reads back as one, and later bus activity cannot disturb the address and byte that were captured when the write started.

A read finishes one cycle after it is requested. The controller also drives a level interrupt that stays high while it is idle, as long as the enable bit and the global interrupt input are both set.

Top module: `nv_store_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `irq_o` is low, and no store strobe is active.
- R2: Register select 0 is the low address byte and select 1 is the high address byte. Only bit 0 of the high byte is kept, and bits 7:1 of it read as zero. `mem_addr_o` equals {high bit 0, low byte} while the block is idle.
- R3: Register select 3 is the control register, with this bit layout: bit 3 is the interrupt enable (read/write), bit 2 is the arm bit, bit 1 is the write request/busy bit and bit 0 is the read request bit. Bits 7:4 read as zero whatever was written to them.
- R4: Writing 1 to control bit 2 arms the block. The arm bit reads as 1 for exactly 4 cycles and then hardware clears it. Writing 0 to bit 2 has no effect.
- R5: Writing 1 to control bit 1 while armed and idle starts a write. Bit 1 then reads 1 for WR_LAT cycles (16 by default). The store receives exactly one write strobe, in the last busy cycle.
- R6: A write request made while not armed has no effect. This covers three cases: arming never happened, the window has expired, or bit 2 and bit 1 are set in the same bus write.
- R7: A write stores the address and data that were held when it started. Bus writes to the address or data registers during busy change neither.
- R8: Writing 1 to control bit 0 while idle loads the addressed byte into the data register (select 2) one cycle later. Bit 0 reads 1 for that one cycle and then clears itself.
- R9: Read or write requests made while a write is busy are ignored. No read strobe reaches the store, no second write is started, and the data register is not reloaded.
- R10: `irq_o` equals interrupt-enable AND `gie_i` AND not-busy, and it holds as a level for as long as those terms are true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Bus write data |
| bus_we_i | input | 1 | Register write enable |
| bus_re_i | input | 1 | Register read enable; read data is zero when low |
| bus_rdata_o | output | 8 | Combinational read data of the selected register |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Ready interrupt level |
| mem_addr_o | output | 9 | Store byte address |
| mem_wdata_o | output | 8 | Store write data |
| mem_we_o | output | 1 | Store write strobe, one cycle per write |
| mem_re_o | output | 1 | Store read strobe, one cycle per read |
| mem_rdata_i | input | 8 | Store read data, valid in the read-strobe cycle |

## Verification
The assertions check several rules on every cycle:
- a write only starts while armed, and arming only follows a bus set;
- the captured address and data stay steady while busy;
- busy ends right after the store strobe;
- the read request clears itself after one cycle;
- no read strobe appears during a write;
- the interrupt is never high while busy.

Some behaviour only the bench scenarios can show. These are the exact four-cycle arming window, the sixteen-cycle busy length, the byte that actually lands at each address including 0 and 511, and the fact that rejected requests leave the store and the data register untouched.

// File: rtl/nv_pkg.sv
package nv_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int CTL_RD  = 0;
  localparam int CTL_WR  = 1;
  localparam int CTL_ARM = 2;
  localparam int CTL_RIE = 3;
endpackage

// File: rtl/nv_arm_window.sv
module nv_arm_window #(
  parameter int ARM_WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic armed_o
);
  localparam int CW = $clog2(ARM_WIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (set_i)        cnt_q <= CW'(ARM_WIN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign armed_o = (cnt_q != '0);

  AST_ARM_FROM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(set_i)); // R4
  AST_SET_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> armed_o); // R4
endmodule

// File: rtl/nv_write_seq.sv
module nv_write_seq #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int WR_LAT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              commit_o
);
  localparam int LW = $clog2(WR_LAT + 1);

  logic [LW-1:0]     lat_q;
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        lat_q  <= LW'(WR_LAT);
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end else if (lat_q == LW'(1)) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      lat_q <= lat_q - 1'b1;
    end
  end

  // store strobe in the final busy cycle
  assign commit_o = busy_q && (lat_q == LW'(1));
  assign busy_o   = busy_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o); // R5
  AST_CAPTURE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(data_o))); // R7
endmodule

// File: rtl/nv_store_ctrl.sv
module nv_store_ctrl
  import nv_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int ARM_WIN = 4,
  parameter int WR_LAT  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_sel_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              gie_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rie_q;
  logic              rd_pend_q;
  logic              armed;
  logic              busy;
  logic              commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              ctl_wr, arm_set, wr_req, rd_req;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(bus_sel_i);
  assign ctl_wr  = bus_we_i && (sel == SEL_CTRL);
  assign arm_set = ctl_wr && bus_wdata_i[CTL_ARM];
  assign wr_req  = ctl_wr && bus_wdata_i[CTL_WR] && armed && !busy && !rd_pend_q;
  assign rd_req  = ctl_wr && bus_wdata_i[CTL_RD] && !busy && !rd_pend_q && !wr_req;

  nv_arm_window #(.ARM_WIN(ARM_WIN)) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (arm_set),
    .armed_o (armed)
  );

  nv_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_LAT(WR_LAT)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wr_req),
    .addr_i   (addr_q),
    .data_i   (data_q),
    .busy_o   (busy),
    .addr_o   (wr_addr),
    .data_o   (wr_data),
    .commit_o (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      data_q    <= '0;
      rie_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_req;
      if (bus_we_i && sel == SEL_ADDR_LO) addr_q[DATA_W-1:0] <= bus_wdata_i;
      if (bus_we_i && sel == SEL_ADDR_HI) addr_q[ADDR_W-1:DATA_W] <= bus_wdata_i[HI_W-1:0];
      if (ctl_wr) rie_q <= bus_wdata_i[CTL_RIE];
      // fetched byte wins over a same-cycle bus write
      if (rd_pend_q)                          data_q <= mem_rdata_i;
      else if (bus_we_i && sel == SEL_DATA)   data_q <= bus_wdata_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      unique case (sel)
        SEL_ADDR_LO: bus_rdata_o = addr_q[DATA_W-1:0];
        SEL_ADDR_HI: bus_rdata_o = {{(DATA_W-HI_W){1'b0}}, addr_q[ADDR_W-1:DATA_W]};
        SEL_DATA:    bus_rdata_o = data_q;
        SEL_CTRL: begin
          bus_rdata_o[CTL_RIE] = rie_q;
          bus_rdata_o[CTL_ARM] = armed;
          bus_rdata_o[CTL_WR]  = busy;
          bus_rdata_o[CTL_RD]  = rd_pend_q;
        end
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign mem_addr_o  = busy ? wr_addr : addr_q;
  assign mem_wdata_o = wr_data;
  assign mem_we_o    = commit;
  assign mem_re_o    = rd_pend_q;
  assign irq_o       = rie_q && gie_i && !busy;

  AST_WR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(armed)); // R6
  AST_RD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |=> !rd_pend_q); // R8
  AST_NO_RD_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> !busy); // R9
  AST_IRQ_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy); // R10
  AST_STROBES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o)); // R5
endmodule

// File: tb/nv_store_ctrl_bench.sv
module nv_store_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WR_LAT = 16;
  localparam int NVEC = 6;
  // {address, data}
  localparam logic [16:0] VEC [NVEC] = '{
    {9'h000, 8'hA1}, {9'h1FF, 8'h5E}, {9'h0FF, 8'h00},
    {9'h100, 8'hFF}, {9'h0AA, 8'h3C}, {9'h155, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] wd = '0;
  logic       we = 1'b0, re = 1'b0, gie = 1'b0;
  logic [7:0] rdata, mem_wdata, mem_rdata;
  logic [8:0] mem_addr;
  logic       irq, mem_we, mem_re;
  logic [7:0] mem [512];
  int         total = 0, bad = 0, we_cnt = 0, re_busy = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_store_ctrl u_nv_store_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wdata_i(wd),
    .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata), .gie_i(gie),
    .irq_o(irq), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    sel = s; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
    sel = s; re = 1'b1;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_addr(input logic [8:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, {7'd0, a[8]});
  endtask

  task automatic do_write(input logic [8:0] a, input logic [7:0] d);
    set_addr(a);
    bus_wr(2'd2, d);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    idle(WR_LAT);
  endtask

  task automatic do_read(input logic [8:0] a, output logic [7:0] d);
    set_addr(a);
    bus_wr(2'd3, 8'h01);
    idle(1);
    bus_rd(2'd2, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int         w0;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'h5A;
    idle(3);
    // R1: reset state
    bus_rd(2'd3, r); check("R1 ctrl", {8'h0, r}, 16'h0000);
    check("R1 irq", {15'h0, irq}, 16'h0);
    check("R1 strobes", {14'h0, mem_we, mem_re}, 16'h0);
    rst_n = 1'b1;
    idle(1);
    gie = 1'b1;

    // R3 + R10: reserved bits, interrupt enable
    bus_wr(2'd3, 8'hF8);
    bus_rd(2'd3, r); check("R3 ctrl reserved", {8'h0, r}, 16'h0008);
    check("R10 irq idle", {15'h0, irq}, 16'h1);
    gie = 1'b0; #1;
    check("R10 irq gie low", {15'h0, irq}, 16'h0);
    gie = 1'b1;
    bus_wr(2'd3, 8'h00);

    // R2: address split
    bus_wr(2'd1, 8'hFF);
    bus_wr(2'd0, 8'hA5);
    bus_rd(2'd1, r); check("R2 addr hi", {8'h0, r}, 16'h0001);
    bus_rd(2'd0, r); check("R2 addr lo", {8'h0, r}, 16'h00A5);
    check("R2 mem_addr", {7'h0, mem_addr}, 16'h01A5);

    // R4: arming window length
    bus_wr(2'd3, 8'h04);
    bus_rd(2'd3, r); check("R4 armed", {15'h0, r[2]}, 16'h1);
    idle(3);
    bus_rd(2'd3, r); check("R4 armed c4", {15'h0, r[2]}, 16'h1);
    idle(1);
    bus_rd(2'd3, r); check("R4 auto clear", {15'h0, r[2]}, 16'h0);

    // R6: unarmed, expired and same-write requests
    w0 = we_cnt;
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, r); check("R6 unarmed", {15'h0, r[1]}, 16'h0);
    bus_wr(2'd3, 8'h04);
    idle(4);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, r); check("R6 expired", {15'h0, r[1]}, 16'h0);
    idle(4);
    bus_wr(2'd3, 8'h06);
    bus_rd(2'd3, r); check("R6 same write", {15'h0, r[1]}, 16'h0);
    idle(WR_LAT + 2);
    check("R6 no store write", 16'(we_cnt - w0), 16'h0);

    // R5: busy length and single strobe
    w0 = we_cnt;
    set_addr(9'h033);
    bus_wr(2'd2, 8'h77);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h0A);
    bus_rd(2'd3, r); check("R5 busy set", {15'h0, r[1]}, 16'h1);
    check("R10 irq busy", {15'h0, irq}, 16'h0);
    idle(WR_LAT - 1);
    bus_rd(2'd3, r); check("R5 busy last", {15'h0, r[1]}, 16'h1);
    idle(1);
    bus_rd(2'd3, r); check("R5 busy end", {15'h0, r[1]}, 16'h0);
    check("R10 irq back", {15'h0, irq}, 16'h1);
    check("R5 one strobe", 16'(we_cnt - w0), 16'h1);
    check("R5 stored", {8'h0, mem[9'h033]}, 16'h0077);

    // table walk: R5 writes, R8 read back
    for (int i = 0; i < NVEC; i++) do_write(VEC[i][16:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) begin
      do_read(VEC[i][16:8], r);
      check("R8 table read", {8'h0, r}, {8'h0, VEC[i][7:0]});
    end

    // R8: read strobe self clear
    set_addr(9'h123);
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd3, r); check("R8 rd pending", {15'h0, r[0]}, 16'h1);
    idle(1);
    bus_rd(2'd3, r); check("R8 rd cleared", {15'h0, r[0]}, 16'h0);
    bus_rd(2'd2, r); check("R8 data", {8'h0, r}, {8'h0, 8'h23 ^ 8'h5A});

    // R7 + R9: bus activity during busy
    w0 = we_cnt;
    set_addr(9'h0F0);
    bus_wr(2'd2, 8'h3C);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    re_busy = 0;
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd2, 8'h99);
    bus_wr(2'd3, 8'h01);
    if (mem_re) re_busy++;
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, r); check("R9 still busy", {15'h0, r[1]}, 16'h1);
    idle(WR_LAT - 5);
    bus_rd(2'd3, r); check("R9 idle", {15'h0, r[1]}, 16'h0);
    check("R9 no read strobe", 16'(re_busy), 16'h0);
    check("R9 one write", 16'(we_cnt - w0), 16'h1);
    bus_rd(2'd2, r); check("R9 data kept", {8'h0, r}, 16'h0099);
    idle(WR_LAT + 2);
    check("R9 no late write", 16'(we_cnt - w0), 16'h1);
    do_read(9'h0F0, r); check("R7 captured", {8'h0, r}, 16'h003C);
    do_read(9'h011, r); check("R7 other addr", {8'h0, r}, {8'h0, 8'h11 ^ 8'h5A});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule